// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter with External Release

This block decides which of four masters drives a shared system bus: an off-chip master that asks through an active-low request pin, a memory refresh engine, a DMA engine and the CPU. The CPU holds the bus whenever no other master wants it. Ownership changes only at legal points. Each master reports its own transfer boundaries, and a DMA move is treated as an indivisible read-then-write pair. Between two owners there is always one clock with no grant, so no two masters ever drive the bus at once.

The off-chip request is registered on every rising clock edge. It is acted on only while the release-enable input is 1. While the bus is released, the block pulls its acknowledge output low, turns off the on-chip bus drivers (address, data and strobes go to high impedance) and forces every chip select to its inactive high level. The release ends only after the request pin has been seen high on two edges in a row.

Top module: `bus_arbiter_xr`

## Requirements
- R1: During and after reset the CPU owns the bus. Grant is 4'b0001, ext_ack_n=1, bus_oe=1, cs_hold_hi=0, and both stored samples of ext_req_n read high.
- R2: gnt is one-hot or zero, with bit 0=CPU, bit 1=DMA, bit 2=refresh and bit 3=external. Every change of owner passes through exactly one cycle with gnt=0.
- R3: When the bus is free, the winner is chosen in this order: external (if enabled), then refresh, then DMA, then CPU. The CPU is the default owner when nothing requests the bus.
- R4: An external request wins only if rel_en=1 in the cycle the grant is decided. If rel_en is cleared before that, the request is ignored. Clearing rel_en during a release has no effect, and the release continues.
- R5: ext_req_n is sampled on each rising edge. If it is low before edge E1 and the CPU sits at a boundary (cpu_bnd=1), gnt is 0 after edge E2 and gnt[3] is 1 after edge E3.
- R6: While the external master owns the bus: ext_ack_n=0, bus_oe=0 and cs_hold_hi=1. In every other state: ext_ack_n=1, bus_oe=1 and cs_hold_hi=0.
- R7: A release ends only after ext_req_n is high before two consecutive edges E1 and E2. Then ext_ack_n returns high after edge E3. A single high sample has no effect.
- R8: When the DMA engine is granted, its first dma_cyc_done pulse marks its read and the second marks its write. The bus never leaves the DMA engine between the two. A waiting master takes over only after the write's pulse, or when the DMA engine is idle between pairs (dma_req=0).
- R9: The refresh engine gives up the bus on the edge where rfsh_done=1, or when it stops requesting.
- R10: The CPU gives up the bus only on an edge where cpu_bnd=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rel_en | input | 1 | Allows the bus to be released to the external master |
| ext_req_n | input | 1 | Active-low bus request from the external master |
| rfsh_req | input | 1 | Refresh engine wants the bus |
| rfsh_done | input | 1 | Refresh cycle finished (one-cycle pulse) |
| dma_req | input | 1 | DMA engine wants the bus |
| dma_cyc_done | input | 1 | DMA bus cycle (read or write half) finished |
| cpu_bnd | input | 1 | CPU is at a bus-cycle boundary and may give up the bus |
| gnt | output | 4 | One-hot grant: 0 CPU, 1 DMA, 2 refresh, 3 external |
| ext_ack_n | output | 1 | Active-low acknowledge to the external master |
| bus_oe | output | 1 | 1 lets on-chip address/data/strobe drivers drive; 0 tri-states them |
| cs_hold_hi | output | 1 | 1 forces all chip selects to their inactive high level |

## Verification
Each result has a fixed due cycle, counted from the falling edge where the bench applies a stimulus. For an on-chip request, the owner is dropped one edge later and the new grant appears on the next edge. For the external pin, the input register adds one more edge, so the grant is due after the third edge. Likewise, the end of a release is due after the third edge that follows the first of two high samples. The bench drives inputs on falling edges and advances an exact number of falling edges before sampling. It also checks the intermediate gap cycle and the cycle just before each due point, so an output that moves one cycle early or late is caught.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int N_MST = 4;

  typedef enum logic [2:0] {
    OWN_CPU  = 3'd0,
    OWN_DMA  = 3'd1,
    OWN_RFSH = 3'd2,
    OWN_EXT  = 3'd3,
    OWN_NONE = 3'd4
  } owner_t;

  // fixed priority: external > refresh > DMA > CPU
  function automatic owner_t pick_winner(input logic ext_ok, input logic rfsh, input logic dma);
    if (ext_ok)    return OWN_EXT;
    else if (rfsh) return OWN_RFSH;
    else if (dma)  return OWN_DMA;
    else           return OWN_CPU;
  endfunction

  function automatic logic [N_MST-1:0] grant_of(input owner_t o);
    logic [N_MST-1:0] g;
    g = '0;
    for (int i = 0; i < N_MST; i++)
      if (o == owner_t'(i)) g[i] = 1'b1;
    return g;
  endfunction
endpackage

// File: rtl/xreq_sampler.sv
module xreq_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic want,
  output logic quit
);
  logic smp_now, smp_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_now  <= 1'b1;
      smp_prev <= 1'b1;
    end else begin
      smp_now  <= req_n;
      smp_prev <= smp_now;
    end
  end

  assign want = !smp_now;
  assign quit = smp_now && smp_prev;
endmodule

// File: rtl/dma_pair_tracker.sv
module dma_pair_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cyc_done,
  input  logic dma_req,
  output logic in_write,
  output logic boundary
);
  logic xfer_end, idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  in_write <= 1'b0;
    else if (active && cyc_done) in_write <= !in_write;
  end

  assign xfer_end = active && cyc_done && in_write;
  assign idle     = active && !dma_req && !in_write;
  assign boundary = xfer_end || idle;

  // R8
  no_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && in_write && !cyc_done) |=> active);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ext_ok,
  input  logic   ext_quit,
  input  logic   rfsh_req,
  input  logic   rfsh_done,
  input  logic   dma_req,
  input  logic   dma_bnd,
  input  logic   cpu_bnd,
  output owner_t own
);
  owner_t win, nxt;

  assign win = pick_winner(ext_ok, rfsh_req, dma_req);

  always_comb begin
    nxt = own;
    unique case (own)
      OWN_CPU:  if (cpu_bnd && win != OWN_CPU) nxt = OWN_NONE;
      OWN_DMA:  if (dma_bnd && win != OWN_DMA) nxt = OWN_NONE;
      OWN_RFSH: if (rfsh_done || !rfsh_req)    nxt = OWN_NONE;
      OWN_EXT:  if (ext_quit)                  nxt = OWN_NONE;
      default:                                 nxt = win;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own <= OWN_CPU;
    else        own <= nxt;
  end

  // R2
  gap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own == OWN_NONE) |=> (own != OWN_NONE));
endmodule

// File: rtl/bus_arbiter_xr.sv
module bus_arbiter_xr
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_en,
  input  logic             ext_req_n,
  input  logic             rfsh_req,
  input  logic             rfsh_done,
  input  logic             dma_req,
  input  logic             dma_cyc_done,
  input  logic             cpu_bnd,
  output logic [N_MST-1:0] gnt,
  output logic             ext_ack_n,
  output logic             bus_oe,
  output logic             cs_hold_hi
);
  logic   ext_want, ext_quit, dma_in_write, dma_bnd;
  owner_t own;

  xreq_sampler u_smp (
    .clk   (clk),
    .rst_n (rst_n),
    .req_n (ext_req_n),
    .want  (ext_want),
    .quit  (ext_quit)
  );

  dma_pair_tracker u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (own == OWN_DMA),
    .cyc_done (dma_cyc_done),
    .dma_req  (dma_req),
    .in_write (dma_in_write),
    .boundary (dma_bnd)
  );

  arb_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_ok    (ext_want && rel_en),
    .ext_quit  (ext_quit),
    .rfsh_req  (rfsh_req),
    .rfsh_done (rfsh_done),
    .dma_req   (dma_req),
    .dma_bnd   (dma_bnd),
    .cpu_bnd   (cpu_bnd),
    .own       (own)
  );

  logic released;
  assign released   = (own == OWN_EXT);
  assign gnt        = grant_of(own);
  assign ext_ack_n  = !released;
  assign bus_oe     = !released;
  assign cs_hold_hi = released;

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && $past(gnt) != '0) |-> (gnt == $past(gnt)));

  // R4
  enable_at_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt[3]) |-> $past(rel_en));

  // R7
  two_high_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ack_n) |-> ($past(ext_req_n, 2) && $past(ext_req_n, 3)));

  // R10
  cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 4'b0001 && !cpu_bnd) |=> (gnt == 4'b0001));

  // R8: write half pending keeps DMA as owner
  dma_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 4'b0010 && dma_in_write && !dma_cyc_done) |=> (gnt == 4'b0010));
endmodule

// File: tb/bus_arbiter_xr_tb.sv
`timescale 1ns/1ps
module bus_arbiter_xr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rel_en = 1'b0, ext_req_n = 1'b1, rfsh_req = 1'b0, rfsh_done = 1'b0;
  logic dma_req = 1'b0, dma_cyc_done = 1'b0, cpu_bnd = 1'b1;
  logic [3:0] gnt;
  logic ext_ack_n, bus_oe, cs_hold_hi;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  bus_arbiter_xr u_dut (
    .clk(clk), .rst_n(rst_n), .rel_en(rel_en), .ext_req_n(ext_req_n),
    .rfsh_req(rfsh_req), .rfsh_done(rfsh_done), .dma_req(dma_req),
    .dma_cyc_done(dma_cyc_done), .cpu_bnd(cpu_bnd), .gnt(gnt),
    .ext_ack_n(ext_ack_n), .bus_oe(bus_oe), .cs_hold_hi(cs_hold_hi)
  );

  // {rel_en, ext request, rfsh_req, dma_req, expected gnt}
  localparam logic [7:0] VEC [0:7] = '{
    8'b1111_1000, 8'b0111_0100, 8'b0011_0100, 8'b0001_0010,
    8'b1101_1000, 8'b0100_0001, 8'b0000_0001, 8'b1100_1000
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_dma();
    dma_cyc_done = 1'b1; tick(1); dma_cyc_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [2:0] side_exp(input logic rel);
    return rel ? 3'b001 : 3'b110;
  endfunction

  initial begin
    tick(3);
    check("R1 gnt in reset", gnt, 4'b0001);
    rst_n = 1'b1;
    tick(1);
    check("R1 gnt", gnt, 4'b0001);
    check("R1 ack/oe/cs", {ext_ack_n, bus_oe, cs_hold_hi}, 3'b110);

    // R3 priority table walk
    for (int i = 0; i < 8; i++) begin
      rel_en = VEC[i][7]; ext_req_n = !VEC[i][6];
      rfsh_req = VEC[i][5]; dma_req = VEC[i][4];
      tick(3);
      check($sformatf("R3 vec%0d gnt", i), gnt, VEC[i][3:0]);
      check($sformatf("R6 vec%0d ack/oe/cs", i), {ext_ack_n, bus_oe, cs_hold_hi},
            side_exp(VEC[i][3]));
      ext_req_n = 1'b1; rfsh_req = 1'b0; dma_req = 1'b0; rfsh_done = 1'b1;
      tick(1); rfsh_done = 1'b0;
      tick(5);
      check($sformatf("R3 vec%0d back to cpu", i), gnt, 4'b0001);
    end
    rel_en = 1'b0;

    // R10 CPU holds without boundary
    cpu_bnd = 1'b0; dma_req = 1'b1;
    tick(4);
    check("R10 cpu holds", gnt, 4'b0001);
    cpu_bnd = 1'b1;
    tick(1);
    check("R2 gap cpu->dma", gnt, 4'b0000);
    tick(1);
    check("R10 dma granted", gnt, 4'b0010);

    // R8 read/write pair not split
    rfsh_req = 1'b1; pulse_dma();
    tick(3);
    check("R8 dma kept after read", gnt, 4'b0010);
    pulse_dma();
    check("R2 gap dma->rfsh", gnt, 4'b0000);
    tick(1);
    check("R8 rfsh after write", gnt, 4'b0100);

    // R9 refresh release
    rfsh_done = 1'b1; rfsh_req = 1'b0;
    tick(1); rfsh_done = 1'b0;
    check("R9 gap after refresh", gnt, 4'b0000);
    tick(1);
    check("R9 dma back", gnt, 4'b0010);

    // R4 enable cleared while pending
    pulse_dma();
    rel_en = 1'b1; ext_req_n = 1'b0;
    tick(2);
    rel_en = 1'b0;
    tick(1);
    pulse_dma();
    tick(2);
    check("R4 pending ignored gnt", gnt, 4'b0010);
    check("R4 pending ignored ack", ext_ack_n, 1'b1);

    // R4 release in progress survives clearing
    rel_en = 1'b1; dma_req = 1'b0;
    tick(2);
    check("R4 ext granted", gnt, 4'b1000);
    rel_en = 1'b0;
    tick(4);
    check("R4 release kept", ext_ack_n, 1'b0);

    // R7 single high sample ignored, two highs end release
    ext_req_n = 1'b1; tick(1); ext_req_n = 1'b0;
    tick(4);
    check("R7 one high ignored", ext_ack_n, 1'b0);
    ext_req_n = 1'b1;
    tick(2);
    check("R7 ack low before due", ext_ack_n, 1'b0);
    tick(1);
    check("R7 ack high", ext_ack_n, 1'b1);
    check("R7 gap", gnt, 4'b0000);
    tick(1);
    check("R3 cpu default", gnt, 4'b0001);

    // R5 sampling latency
    rel_en = 1'b1; ext_req_n = 1'b0;
    tick(2);
    check("R5 gap at edge 2", gnt, 4'b0000);
    tick(1);
    check("R5 ext at edge 3", gnt, 4'b1000);
    check("R6 released outputs", {ext_ack_n, bus_oe, cs_hold_hi}, 3'b001);
    ext_req_n = 1'b1;
    tick(6);
    check("R6 restored outputs", {ext_ack_n, bus_oe, cs_hold_hi}, 3'b110);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule